// File: doc/BRIEF.md
# DMA Master Bus-Error Abort Controller

This block sits on the single request path from the transmit and receive DMA engines to the bus-master port. It issues each request to the bus with its address unchanged and follows the response beats. From the type tag each request carries, it decides whether an error response counts as a fault. Reads of descriptors and of transmit data are faults. Receive data writes and descriptor writes are posted, so their error responses are dropped.

A fault sets a sticky halt state. After that, every new request is refused at once and never reaches the bus. A level interrupt reports the halt state and can be masked by an enable bit. A descriptor read that faults is cut short: the bus gets a kill strobe and later beats are no longer passed on. A transmit read that faults is reported to the transmit path. If the request is not the last transfer of the frame, a data-error pulse is raised. If it is the last transfer, the report moves to the close step. Only a hardware reset or the self-clearing soft-reset bit of the control word clears the halt.

The sequencer has six named states. `S_IDLE` accepts a request. It goes to `S_ISSUE` when not halted and to `S_REJECT` when halted. `S_ISSUE` holds the bus request until `bus_ready`, then goes to `S_WAIT`. `S_WAIT` follows the beats. It goes to `S_KILL` on a faulting descriptor-read beat and to `S_CLOSE` on the final beat. `S_KILL`, `S_CLOSE` and `S_REJECT` each return a one-cycle completion to the engine and go back to `S_IDLE`. A soft reset forces `S_IDLE` from any state.

Top module: `dma_berr_guard`

## Requirements
- R1: An error beat on a descriptor-read (kind 00) or transmit-read (kind 01) request sets the halt state one clock after the beat is taken. With interrupt enable (control bit 0) set, `irq` is high from then on.
- R2: While halted, `bus_valid` stays low for every request the engines make.
- R3: A request accepted while halted completes with `done_valid` high and `done_code` = 10 (aborted) in the cycle after acceptance.
- R4: An error beat on a descriptor read gives `bus_kill` and `done_code` = 01 (bus error) in the next cycle. Later beats of that read are not forwarded on `eng_beat_valid`.
- R5: A transmit-read error with `req_last` = 0 pulses `tx_err_data` for one cycle, one clock after the error beat. The request completes with code 01 after its final beat.
- R6: A transmit-read error with `req_last` = 1 leaves `tx_err_data` low. It raises `tx_err_close` in the completion cycle, together with code 01.
- R7: Error beats on receive-write (kind 10) or descriptor-write (kind 11) requests never set the halt state, and the request completes with code 00 (ok).
- R8: `bus_addr` during the bus request equals the address the engine gave, with no change.
- R9: With interrupt enable clear, `irq` stays low even when halted, and requests are still refused.
- R10: Writing control bit 1 (soft reset) makes `srst_pending` high for exactly one cycle. It clears the halt state and returns the sequencer to idle.
- R11: After hardware reset: `irq`, `bus_valid`, `done_valid` and `srst_pending` are low, `req_ready` is high, and interrupt enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 2 | Control word: bit 0 interrupt enable, bit 1 soft reset |
| srst_pending | output | 1 | Soft-reset bit readback (self-clearing) |
| irq | output | 1 | Bus-error interrupt, level high |
| req_valid | input | 1 | Engine request |
| req_ready | output | 1 | Request accepted this cycle |
| req_kind | input | 2 | 00 desc read, 01 tx read, 10 rx write, 11 desc write |
| req_last | input | 1 | Request is the last transfer of its frame |
| req_addr | input | AW | Request address |
| done_valid | output | 1 | Completion strobe to the engine |
| done_code | output | 2 | 00 ok, 01 bus error, 10 aborted |
| bus_valid | output | 1 | Bus request |
| bus_ready | input | 1 | Bus took the request |
| bus_kind | output | 2 | Kind of the request in progress |
| bus_addr | output | AW | Bus address |
| beat_valid | input | 1 | Response beat present |
| beat_err | input | 1 | Beat carries an error response |
| beat_last | input | 1 | Final beat of the transaction |
| eng_beat_valid | output | 1 | Beat forwarded to the engine |
| bus_kill | output | 1 | Terminate the current read on the bus |
| tx_err_data | output | 1 | Transmit error reported with the data |
| tx_err_close | output | 1 | Transmit error reported at the close step |

## Verification
A request accepted at one edge shows `bus_valid` or its abort completion in the cycle after. An error beat taken at an edge shows the halt, `tx_err_data` or the kill completion one cycle later. A normal completion appears in the cycle after the final beat. The bench drives every input on the falling edge and reads the outputs on the next falling edge, half a period after the edge that registered them. A scoreboard queue gets each expected completion code before the request is made. A monitor compares the codes on every falling edge where `done_valid` is high.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    typedef enum logic [1:0] {
        XK_DESC_RD = 2'b00,
        XK_TX_RD   = 2'b01,
        XK_RX_WR   = 2'b10,
        XK_DESC_WR = 2'b11
    } xfer_kind_e;

    typedef enum logic [1:0] {
        DC_OK      = 2'b00,
        DC_BUSERR  = 2'b01,
        DC_ABORTED = 2'b10,
        DC_RSVD    = 2'b11
    } done_code_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_ISSUE  = 3'd1,
        S_WAIT   = 3'd2,
        S_KILL   = 3'd3,
        S_CLOSE  = 3'd4,
        S_REJECT = 3'd5
    } seq_state_e;

    localparam int CFG_W    = 2;
    localparam int IEN_BIT  = 0;
    localparam int SRST_BIT = 1;

    // Reads are the only kinds whose error responses count as faults.
    function automatic logic kind_reports(input logic [1:0] k);
        return (k == XK_DESC_RD) || (k == XK_TX_RD);
    endfunction

endpackage

// File: rtl/dbg_ctrl_regs.sv
module dbg_ctrl_regs
    import dbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             irq_en,
    output logic             srst_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
            srst_q <= 1'b0;
        end else begin
            if (cfg_wr) begin
                irq_en <= cfg_wdata[IEN_BIT];
            end
            // Set only in the cycle after a write that carries the bit.
            srst_q <= cfg_wr && cfg_wdata[SRST_BIT];
        end
    end

endmodule

// File: rtl/dbg_xfer_seq.sv
module dbg_xfer_seq
    import dbg_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          halted,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_kind,
    input  logic          req_last,
    input  logic [AW-1:0] req_addr,
    output logic          done_valid,
    output logic [1:0]    done_code,
    output logic          bus_valid,
    input  logic          bus_ready,
    output logic [1:0]    bus_kind,
    output logic [AW-1:0] bus_addr,
    input  logic          beat_valid,
    input  logic          beat_err,
    input  logic          beat_last,
    output logic          eng_beat_valid,
    output logic          bus_kill,
    output logic          err_evt,
    output logic          closing,
    output logic          err_seen,
    output logic          last_q
);

    seq_state_e    state, nxt;
    logic [1:0]    kind_q;
    logic [AW-1:0] addr_q;
    logic          accept;

    assign accept  = (state == S_IDLE) && req_valid && !flush;
    assign err_evt = (state == S_WAIT) && beat_valid && beat_err && kind_reports(kind_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else if (flush) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Request capture and fault memory for the transaction in progress
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q   <= 2'b00;
            addr_q   <= '0;
            last_q   <= 1'b0;
            err_seen <= 1'b0;
        end else if (accept) begin
            kind_q   <= req_kind;
            addr_q   <= req_addr;
            last_q   <= req_last;
            err_seen <= 1'b0;
        end else if (err_evt) begin
            err_seen <= 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (req_valid) begin
                    nxt = halted ? S_REJECT : S_ISSUE;
                end
            end
            S_ISSUE: begin
                if (bus_ready) begin
                    nxt = S_WAIT;
                end
            end
            S_WAIT: begin
                if (beat_valid) begin
                    if (err_evt && (kind_q == XK_DESC_RD)) begin
                        nxt = S_KILL;
                    end else if (beat_last) begin
                        nxt = S_CLOSE;
                    end
                end
            end
            S_KILL:   nxt = S_IDLE;
            S_CLOSE:  nxt = S_IDLE;
            S_REJECT: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready      = (state == S_IDLE) && !flush;
        bus_valid      = (state == S_ISSUE);
        bus_addr       = addr_q;
        bus_kind       = kind_q;
        eng_beat_valid = (state == S_WAIT) && beat_valid;
        bus_kill       = 1'b0;
        done_valid     = 1'b0;
        done_code      = DC_OK;
        closing        = 1'b0;
        unique case (state)
            S_KILL: begin
                bus_kill   = 1'b1;
                done_valid = 1'b1;
                done_code  = DC_BUSERR;
            end
            S_CLOSE: begin
                closing    = 1'b1;
                done_valid = 1'b1;
                done_code  = err_seen ? DC_BUSERR : DC_OK;
            end
            S_REJECT: begin
                done_valid = 1'b1;
                done_code  = DC_ABORTED;
            end
            default: begin
                done_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dbg_err_track.sv
module dbg_err_track
    import dbg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       err_evt,
    input  logic       closing,
    input  logic       err_seen,
    input  logic       last_q,
    input  logic [1:0] kind,
    input  logic       irq_en,
    output logic       halted,
    output logic       irq,
    output logic       tx_err_data,
    output logic       tx_err_close
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halted      <= 1'b0;
            tx_err_data <= 1'b0;
        end else if (flush) begin
            halted      <= 1'b0;
            tx_err_data <= 1'b0;
        end else begin
            if (err_evt) begin
                halted <= 1'b1;
            end
            tx_err_data <= err_evt && (kind == XK_TX_RD) && !last_q;
        end
    end

    assign tx_err_close = closing && err_seen && (kind == XK_TX_RD) && last_q;
    assign irq          = halted && irq_en;

endmodule

// File: rtl/dma_berr_guard.sv
module dma_berr_guard
    import dbg_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_wdata,
    output logic          srst_pending,
    output logic          irq,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_kind,
    input  logic          req_last,
    input  logic [AW-1:0] req_addr,
    output logic          done_valid,
    output logic [1:0]    done_code,
    output logic          bus_valid,
    input  logic          bus_ready,
    output logic [1:0]    bus_kind,
    output logic [AW-1:0] bus_addr,
    input  logic          beat_valid,
    input  logic          beat_err,
    input  logic          beat_last,
    output logic          eng_beat_valid,
    output logic          bus_kill,
    output logic          tx_err_data,
    output logic          tx_err_close
);

    logic irq_en;
    logic halted;
    logic err_evt;
    logic closing;
    logic err_seen;
    logic last_q;

    dbg_ctrl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .irq_en    (irq_en),
        .srst_q    (srst_pending)
    );

    dbg_xfer_seq #(.AW(AW)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush          (srst_pending),
        .halted         (halted),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_kind       (req_kind),
        .req_last       (req_last),
        .req_addr       (req_addr),
        .done_valid     (done_valid),
        .done_code      (done_code),
        .bus_valid      (bus_valid),
        .bus_ready      (bus_ready),
        .bus_kind       (bus_kind),
        .bus_addr       (bus_addr),
        .beat_valid     (beat_valid),
        .beat_err       (beat_err),
        .beat_last      (beat_last),
        .eng_beat_valid (eng_beat_valid),
        .bus_kill       (bus_kill),
        .err_evt        (err_evt),
        .closing        (closing),
        .err_seen       (err_seen),
        .last_q         (last_q)
    );

    dbg_err_track u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (srst_pending),
        .err_evt      (err_evt),
        .closing      (closing),
        .err_seen     (err_seen),
        .last_q       (last_q),
        .kind         (bus_kind),
        .irq_en       (irq_en),
        .halted       (halted),
        .irq          (irq),
        .tx_err_data  (tx_err_data),
        .tx_err_close (tx_err_close)
    );

endmodule

// File: rtl/dbg_guard_chk.sv
module dbg_guard_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_wr,
    input logic [1:0]    cfg_wdata,
    input logic          srst_pending,
    input logic          halted,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic          done_valid,
    input logic [1:0]    done_code,
    input logic          bus_valid,
    input logic [1:0]    bus_kind,
    input logic [AW-1:0] bus_addr,
    input logic          beat_err,
    input logic          eng_beat_valid
);

    a_r1_read_err_halts: assert property (@(posedge clk) disable iff (!rst_n || srst_pending)
        (eng_beat_valid && beat_err && !bus_kind[1]) |=> halted);

    a_r2_no_issue_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !bus_valid);

    a_r3_abort_done: assert property (@(posedge clk) disable iff (!rst_n || srst_pending)
        (req_valid && req_ready && halted) |=> (done_valid && done_code == 2'b10));

    a_r7_posted_silent: assert property (@(posedge clk) disable iff (!rst_n || srst_pending)
        (eng_beat_valid && beat_err && bus_kind[1] && !halted) |=> !halted);

    a_r8_addr_through: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_valid) |-> (bus_addr == $past(req_addr)));

    a_r10_srst_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_pending && !(cfg_wr && cfg_wdata[1])) |=> !srst_pending);

    a_r10_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        srst_pending |=> !halted);

endmodule

bind dma_berr_guard dbg_guard_chk #(.AW(AW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wr         (cfg_wr),
    .cfg_wdata      (cfg_wdata),
    .srst_pending   (srst_pending),
    .halted         (halted),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_addr       (req_addr),
    .done_valid     (done_valid),
    .done_code      (done_code),
    .bus_valid      (bus_valid),
    .bus_kind       (bus_kind),
    .bus_addr       (bus_addr),
    .beat_err       (beat_err),
    .eng_beat_valid (eng_beat_valid)
);

// File: tb/test_dma_berr_guard.sv
module test_dma_berr_guard;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_wdata = 2'b00;
    logic          srst_pending, irq;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = 2'b00;
    logic          req_last = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          done_valid;
    logic [1:0]    done_code;
    logic          bus_valid;
    logic          bus_ready = 1'b0;
    logic [1:0]    bus_kind;
    logic [AW-1:0] bus_addr;
    logic          beat_valid = 1'b0, beat_err = 1'b0, beat_last = 1'b0;
    logic          eng_beat_valid, bus_kill, tx_err_data, tx_err_close;

    int n_tests = 0;
    int n_fail  = 0;
    logic [1:0] exp_q[$];

    always #2.5 clk = ~clk;

    dma_berr_guard #(.AW(AW)) i_dma_berr_guard (.*);

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard monitor: every completion is compared with the queued expectation.
    always @(negedge clk) begin
        if (rst_n && done_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected completion", int'(done_code), -1);
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                chk(done_code == e, "R3/R4/R5/R7 completion code", int'(done_code), int'(e));
            end
        end
    end

    task automatic cfg_write(input logic [1:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = 2'b00;
    endtask

    // Drives one request and plays the bus side. errb < 0 means no error beat.
    task automatic xfer(input logic [1:0] kind, input logic last, input logic [AW-1:0] addr,
                        input int nbeats, input int errb, input logic [1:0] expc,
                        input logic issued);
        logic killed;
        killed = 1'b0;
        exp_q.push_back(expc);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_last = last; req_addr = addr;
        @(negedge clk);
        req_valid = 1'b0;
        if (!issued) begin
            chk(!bus_valid, "R2 refused request reaches bus", int'(bus_valid), 0);
            chk(done_valid && done_code == 2'b10, "R3 abort next cycle", int'(done_code), 2);
            return;
        end
        chk(bus_valid, "R2 request issued", int'(bus_valid), 1);
        chk(bus_addr == addr, "R8 address unchanged", int'(bus_addr), int'(addr));
        bus_ready = 1'b1;
        @(negedge clk);
        bus_ready = 1'b0;
        for (int i = 0; i < nbeats; i++) begin
            beat_valid = 1'b1;
            beat_err   = (i == errb);
            beat_last  = (i == nbeats - 1);
            #0.1;
            chk(eng_beat_valid == !killed, "R4 beat forwarding", int'(eng_beat_valid), int'(!killed));
            @(negedge clk);
            beat_valid = 1'b0; beat_err = 1'b0; beat_last = 1'b0;
            if (!killed) begin
                chk(tx_err_data == (i == errb && kind == 2'b01 && !last),
                    "R5 tx data error pulse", int'(tx_err_data),
                    int'(i == errb && kind == 2'b01 && !last));
                if (i == errb && kind == 2'b00) begin
                    chk(bus_kill, "R4 kill strobe", int'(bus_kill), 1);
                    killed = 1'b1;
                end
            end
        end
        if (!killed) begin
            chk(tx_err_close == (errb >= 0 && kind == 2'b01 && last),
                "R6 tx close error", int'(tx_err_close), int'(errb >= 0 && kind == 2'b01 && last));
        end
        @(negedge clk);
    endtask

    task automatic soft_reset();
        cfg_write(2'b11);
        chk(srst_pending, "R10 soft reset bit set", int'(srst_pending), 1);
        @(negedge clk);
        chk(!srst_pending, "R10 soft reset bit self-clears", int'(srst_pending), 0);
        chk(!irq, "R10 halt cleared", int'(irq), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!irq && !bus_valid && !done_valid && !srst_pending && req_ready,
            "R11 reset state", int'(irq), 0);

        xfer(2'b00, 1'b0, 32'h1000_0040, 4, -1, 2'b00, 1'b1);
        chk(!irq, "R1 no fault no irq", int'(irq), 0);

        // R7: posted writes with error responses
        xfer(2'b10, 1'b0, 32'h2000_0000, 3, 1, 2'b00, 1'b1);
        xfer(2'b11, 1'b1, 32'h2000_0100, 2, 1, 2'b00, 1'b1);
        cfg_write(2'b01);
        chk(!irq, "R7 posted errors leave halt clear", int'(irq), 0);
        xfer(2'b01, 1'b0, 32'h3000_0000, 2, -1, 2'b00, 1'b1);
        cfg_write(2'b00);

        // R5, R9: tx error mid-frame with interrupt masked
        xfer(2'b01, 1'b0, 32'h3000_0200, 4, 1, 2'b01, 1'b1);
        chk(!irq, "R9 masked irq", int'(irq), 0);
        xfer(2'b10, 1'b0, 32'h4000_0000, 2, -1, 2'b10, 1'b0);
        cfg_write(2'b01);
        @(negedge clk);
        chk(irq, "R1 irq after enable", int'(irq), 1);
        xfer(2'b00, 1'b0, 32'h4000_0040, 2, -1, 2'b10, 1'b0);
        chk(irq, "R1 irq sticky", int'(irq), 1);
        soft_reset();
        xfer(2'b00, 1'b0, 32'h5000_0000, 2, -1, 2'b00, 1'b1);

        // R6: tx error on last transfer of frame
        xfer(2'b01, 1'b1, 32'h5000_1000, 3, 2, 2'b01, 1'b1);
        chk(irq, "R1 irq after tx fault", int'(irq), 1);
        soft_reset();

        // R4: descriptor read terminated
        xfer(2'b00, 1'b0, 32'h6000_0080, 4, 1, 2'b01, 1'b1);
        chk(irq, "R1 irq after desc fault", int'(irq), 1);
        xfer(2'b01, 1'b0, 32'h6000_00c0, 2, -1, 2'b10, 1'b0);

        // R11: hardware reset clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!irq && req_ready && !srst_pending, "R11 reset after halt", int'(irq), 0);
        xfer(2'b00, 1'b0, 32'h7000_0000, 2, -1, 2'b00, 1'b1);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all completions seen", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule